// File: doc/BRIEF.md
# SATA Lane Override Sequencer

This block runs the recovery loop around a link hard reset on one lane of a multi-lane SerDes. For each attempt it first removes the receive override on the chosen lane. It then asks the link layer for a hard reset and waits for the result. After that it puts the lane back under override: it waits for the lane to leave half rate, forces the receive DPLL into a fixed mode and pulses the DPLL reset. It lets the DPLL settle and then, if the attenuation setting allows it, forces the transmit attenuation. All register traffic goes through an indirect PHY access port as single read or write requests. Each write uses a read-modify-write value built from the last value read or written.

The loop repeats until the link reports online, until no device is detected, or until the retry budget is used up. A one-cycle completion strobe then reports the online flag and the number of hard-reset attempts made. Lane number and attenuation are captured when the start pulse is accepted.

Top module: `lane_ovr_seq`

## Requirements
- R1: After reset, `phy_req`, `hreset_go` and `done` are low. They stay low until `start` is pulsed.
- R2: Lane registers sit at base + lane × 0x100. The bases are 0x2001 (TX status), 0x2002 (RX status), 0x2004 (TX override) and 0x2005 (RX override). Nothing else is accessed, and a pending request holds its address, direction and data until `phy_ack`.
- R3: Before every hard-reset strobe the block reads RX status and writes that value with bit 14 cleared to RX override. While `hreset_go` is high, no PHY request is open.
- R4: After `hreset_done`, RX status is read again and again while bit 0 (half rate) reads 1. The poll stops at POLL_LIMIT reads.
- R5: The RX mode step reads RX status and then writes RX override five times, in this order: bit 14 cleared; bit 14 set; bits 10:8 replaced by DPLL_MODE (3); bit 11 set; bit 11 cleared.
- R6: After the last RX override write is acknowledged, the block issues no request and no strobe for SETTLE_CYCLES cycles.
- R7: The TX step reads TX status and writes TX override three times: bit 15 cleared; bit 15 set; then attenuation bits 2:0 ORed into bits 12:10.
- R8: When attenuation bit 3 is 1, the TX step is skipped and no TX register is touched.
- R9: When the link stays offline, the loop runs at most MAX_RETRY+1 hard-reset attempts and then reports offline.
- R10: When `link_det` reads 0 after an attempt, the loop stops after that attempt's override steps.
- R11: `done` is a one-cycle pulse. With it, `done_online` gives the last attempt's online flag and `done_attempts` gives the number of `hreset_go` strobes.
- R12: A `start` pulse while a run is in progress is ignored. It does not change the lane, the attempt count or the register traffic.
- R13: `hreset_go` is a one-cycle strobe, issued exactly once per attempt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a recovery run (pulse) |
| lane | input | LANE_W | Lane index, captured at start |
| tx_atten | input | 4 | Attenuation setting; bit 3 disables the TX step |
| phy_req | output | 1 | PHY access request, held until acknowledged |
| phy_we | output | 1 | 1 = write, 0 = read |
| phy_addr | output | 16 | PHY register address |
| phy_wdata | output | 16 | Write data |
| phy_ack | input | 1 | One-cycle acknowledge of the open request |
| phy_rdata | input | 16 | Read data, valid with `phy_ack` |
| hreset_go | output | 1 | Hard-reset strobe to the link layer |
| hreset_done | input | 1 | Hard reset finished (pulse) |
| hreset_online | input | 1 | Link online, valid with `hreset_done` |
| link_det | input | 2 | Device detection field, valid with `hreset_done`; 0 = no device |
| done | output | 1 | Run complete (pulse) |
| done_online | output | 1 | Final online flag |
| done_attempts | output | ATT_W | Number of attempts used |

## Verification
The bench builds the block with MAX_RETRY = 3, POLL_LIMIT = 4 and SETTLE_CYCLES = 5. With these values, runs that exhaust the retry budget, a half-rate poll cut off by its limit, and the settle gap can all be observed in a few hundred cycles. The production default for the settle wait is 750000 cycles, which would hide all of these. The small retry budget also keeps the whole write log of a failed run within one short, exactly predicted list.

// File: rtl/lane_ovr_pkg.sv
package lane_ovr_pkg;
  localparam int REG_W = 16;

  // Register bases for lane 0; lanes are spaced by 1 << LANE_SH
  localparam logic [REG_W-1:0] TXSTS_BASE = 16'h2001;
  localparam logic [REG_W-1:0] RXSTS_BASE = 16'h2002;
  localparam logic [REG_W-1:0] TXOVR_BASE = 16'h2004;
  localparam logic [REG_W-1:0] RXOVR_BASE = 16'h2005;
  localparam int LANE_SH = 8;

  // Bit positions
  localparam int HALF_RATE_BIT = 0;
  localparam int DPLL_LSB      = 8;
  localparam int DPLL_RST_BIT  = 11;
  localparam int ATTEN_LSB     = 10;
  localparam int RX_OVR_BIT    = 14;
  localparam int TX_OVR_BIT    = 15;

  typedef enum logic [4:0] {
    S_IDLE, S_DIS_RD, S_DIS_WR, S_RST_GO, S_RST_WAIT, S_POLL_RD,
    S_RXM_RD, S_RXM_W0, S_RXM_W1, S_RXM_W2, S_RXM_W3, S_RXM_W4,
    S_SETTLE, S_TX_RD, S_TX_W0, S_TX_W1, S_TX_W2, S_DECIDE
  } seq_state_t;

  function automatic logic [REG_W-1:0] bit_mask(input int pos);
    return REG_W'(1) << pos;
  endfunction

  function automatic logic [REG_W-1:0] lane_reg(input logic [REG_W-1:0] base,
                                                input logic [7:0] ln);
    return base + (REG_W'(ln) << LANE_SH);
  endfunction

  function automatic logic [REG_W-1:0] set_dpll_mode(input logic [REG_W-1:0] v,
                                                     input logic [2:0] mode);
    return (v & ~(REG_W'(7) << DPLL_LSB)) | (REG_W'(mode) << DPLL_LSB);
  endfunction

  function automatic logic [REG_W-1:0] place_atten(input logic [REG_W-1:0] v,
                                                   input logic [2:0] a);
    return v | (REG_W'(a) << ATTEN_LSB);
  endfunction
endpackage

// File: rtl/lane_ovr_timer.sv
module lane_ovr_timer #(
  parameter int COUNT = 16,
  localparam int CW = $clog2(COUNT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic last
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= CW'(COUNT);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign last = (cnt == CW'(1));
endmodule

// File: rtl/lane_ovr_opgen.sv
module lane_ovr_opgen
  import lane_ovr_pkg::*;
#(
  parameter int LANE_W    = 2,
  parameter int DPLL_MODE = 3
) (
  input  seq_state_t       st,
  input  logic [LANE_W-1:0] ln,
  input  logic [REG_W-1:0] cur,
  input  logic [2:0]       atten,
  output logic             op_active,
  output logic             op_we,
  output logic [REG_W-1:0] op_addr,
  output logic [REG_W-1:0] op_wdata
);
  logic [7:0] ln8;
  assign ln8 = 8'(ln);

  always_comb begin
    op_active = 1'b1;
    op_we     = 1'b1;
    op_addr   = lane_reg(RXOVR_BASE, ln8);
    op_wdata  = cur;
    case (st)
      S_DIS_RD, S_POLL_RD, S_RXM_RD: begin
        op_we   = 1'b0;
        op_addr = lane_reg(RXSTS_BASE, ln8);
      end
      S_DIS_WR, S_RXM_W0: op_wdata = cur & ~bit_mask(RX_OVR_BIT);
      S_RXM_W1: op_wdata = cur | bit_mask(RX_OVR_BIT);
      S_RXM_W2: op_wdata = set_dpll_mode(cur, 3'(DPLL_MODE));
      S_RXM_W3: op_wdata = cur | bit_mask(DPLL_RST_BIT);
      S_RXM_W4: op_wdata = cur & ~bit_mask(DPLL_RST_BIT);
      S_TX_RD: begin
        op_we   = 1'b0;
        op_addr = lane_reg(TXSTS_BASE, ln8);
      end
      S_TX_W0: begin
        op_addr  = lane_reg(TXOVR_BASE, ln8);
        op_wdata = cur & ~bit_mask(TX_OVR_BIT);
      end
      S_TX_W1: begin
        op_addr  = lane_reg(TXOVR_BASE, ln8);
        op_wdata = cur | bit_mask(TX_OVR_BIT);
      end
      S_TX_W2: begin
        op_addr  = lane_reg(TXOVR_BASE, ln8);
        op_wdata = place_atten(cur, atten);
      end
      default: begin
        op_active = 1'b0;
        op_we     = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/lane_ovr_seq.sv
module lane_ovr_seq
  import lane_ovr_pkg::*;
#(
  parameter int LANE_W        = 2,
  parameter int MAX_RETRY     = 100,
  parameter int POLL_LIMIT    = 1000,
  parameter int SETTLE_CYCLES = 750000,
  parameter int DPLL_MODE     = 3,
  localparam int ATT_W = $clog2(MAX_RETRY + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LANE_W-1:0] lane,
  input  logic [3:0]        tx_atten,
  output logic              phy_req,
  output logic              phy_we,
  output logic [REG_W-1:0]  phy_addr,
  output logic [REG_W-1:0]  phy_wdata,
  input  logic              phy_ack,
  input  logic [REG_W-1:0]  phy_rdata,
  output logic              hreset_go,
  input  logic              hreset_done,
  input  logic              hreset_online,
  input  logic [1:0]        link_det,
  output logic              done,
  output logic              done_online,
  output logic [ATT_W-1:0]  done_attempts
);
  localparam int POLL_W = $clog2(POLL_LIMIT + 1);

  seq_state_t        st, op_next;
  logic [LANE_W-1:0] lane_q;
  logic [3:0]        atten_q;
  logic [REG_W-1:0]  cur_q;
  logic              online_q, nodev_q;
  logic [ATT_W-1:0]  att_q;
  logic [POLL_W-1:0] poll_q, poll_inc;
  logic              done_q, done_online_q;
  logic [ATT_W-1:0]  done_att_q;

  logic op_active, op_we, op_done, poll_more, settle_last;
  logic [REG_W-1:0] op_addr, op_wdata;

  // Named internal events, observed by the bound checker
  logic settle_enter, poll_ack;

  lane_ovr_opgen #(.LANE_W(LANE_W), .DPLL_MODE(DPLL_MODE)) u_opgen (
    .st(st), .ln(lane_q), .cur(cur_q), .atten(atten_q[2:0]),
    .op_active(op_active), .op_we(op_we), .op_addr(op_addr), .op_wdata(op_wdata)
  );

  lane_ovr_timer #(.COUNT(SETTLE_CYCLES)) u_settle (
    .clk(clk), .rst_n(rst_n), .load(settle_enter), .last(settle_last)
  );

  assign op_done      = op_active && phy_ack;
  assign settle_enter = (st == S_RXM_W4) && phy_ack;
  assign poll_ack     = (st == S_POLL_RD) && phy_ack;
  assign poll_inc     = poll_q + POLL_W'(1);
  assign poll_more    = phy_rdata[HALF_RATE_BIT] && (poll_inc < POLL_W'(POLL_LIMIT));

  always_comb begin
    op_next = S_IDLE;
    case (st)
      S_DIS_RD:  op_next = S_DIS_WR;
      S_DIS_WR:  op_next = S_RST_GO;
      S_POLL_RD: op_next = poll_more ? S_POLL_RD : S_RXM_RD;
      S_RXM_RD:  op_next = S_RXM_W0;
      S_RXM_W0:  op_next = S_RXM_W1;
      S_RXM_W1:  op_next = S_RXM_W2;
      S_RXM_W2:  op_next = S_RXM_W3;
      S_RXM_W3:  op_next = S_RXM_W4;
      S_RXM_W4:  op_next = S_SETTLE;
      S_TX_RD:   op_next = S_TX_W0;
      S_TX_W0:   op_next = S_TX_W1;
      S_TX_W1:   op_next = S_TX_W2;
      S_TX_W2:   op_next = S_DECIDE;
      default:   op_next = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st            <= S_IDLE;
      lane_q        <= '0;
      atten_q       <= '0;
      cur_q         <= '0;
      online_q      <= 1'b0;
      nodev_q       <= 1'b0;
      att_q         <= '0;
      poll_q        <= '0;
      done_q        <= 1'b0;
      done_online_q <= 1'b0;
      done_att_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (op_done) begin
        cur_q <= op_we ? op_wdata : phy_rdata;
        st    <= op_next;
        if (poll_ack) poll_q <= poll_inc;
      end else begin
        case (st)
          S_IDLE: if (start) begin
            lane_q  <= lane;
            atten_q <= tx_atten;
            att_q   <= '0;
            st      <= S_DIS_RD;
          end
          S_RST_GO: begin
            att_q <= att_q + 1'b1;
            st    <= S_RST_WAIT;
          end
          S_RST_WAIT: if (hreset_done) begin
            online_q <= hreset_online;
            nodev_q  <= (link_det == 2'b00);
            poll_q   <= '0;
            st       <= S_POLL_RD;
          end
          S_SETTLE: if (settle_last) st <= atten_q[3] ? S_DECIDE : S_TX_RD;
          S_DECIDE: begin
            if (nodev_q || online_q || att_q == ATT_W'(MAX_RETRY + 1)) begin
              done_q        <= 1'b1;
              done_online_q <= online_q;
              done_att_q    <= att_q;
              st            <= S_IDLE;
            end else begin
              st <= S_DIS_RD;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign phy_req       = op_active;
  assign phy_we        = op_we;
  assign phy_addr      = op_addr;
  assign phy_wdata     = op_wdata;
  assign hreset_go     = (st == S_RST_GO);
  assign done          = done_q;
  assign done_online   = done_online_q;
  assign done_attempts = done_att_q;
endmodule

// File: rtl/lane_ovr_chk.sv
module lane_ovr_chk #(
  parameter int MAX_RETRY     = 100,
  parameter int POLL_LIMIT    = 1000,
  parameter int SETTLE_CYCLES = 750000,
  localparam int ATT_W = $clog2(MAX_RETRY + 2),
  localparam int PW    = $clog2(POLL_LIMIT + 2),
  localparam int SW    = $clog2(SETTLE_CYCLES + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             phy_req,
  input logic             phy_we,
  input logic [15:0]      phy_addr,
  input logic [15:0]      phy_wdata,
  input logic             phy_ack,
  input logic             hreset_go,
  input logic             done,
  input logic [ATT_W-1:0] done_attempts,
  input logic             settle_enter,
  input logic             poll_ack
);
  logic [PW-1:0] poll_seen;
  logic [SW-1:0] settle_left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         poll_seen <= '0;
    else if (hreset_go) poll_seen <= '0;
    else if (poll_ack)  poll_seen <= poll_seen + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                settle_left <= '0;
    else if (settle_enter)     settle_left <= SW'(SETTLE_CYCLES);
    else if (settle_left != 0) settle_left <= settle_left - 1'b1;
  end

  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    phy_req && !phy_ack |=> phy_req && $stable(phy_addr) && $stable(phy_we) && $stable(phy_wdata));

  assert_addr_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    phy_req |-> (phy_addr[15:10] == 6'b001000) &&
                (phy_addr[7:0] == 8'h01 || phy_addr[7:0] == 8'h02 ||
                 phy_addr[7:0] == 8'h04 || phy_addr[7:0] == 8'h05));

  assert_go_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hreset_go |-> !phy_req);

  assert_poll_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    poll_seen <= PW'(POLL_LIMIT));

  assert_settle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    settle_left != 0 |-> !phy_req && !hreset_go && !done);

  assert_attempt_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> done_attempts >= ATT_W'(1) && done_attempts <= ATT_W'(MAX_RETRY + 1));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_go_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
    hreset_go |=> !hreset_go);
endmodule

bind lane_ovr_seq lane_ovr_chk #(
  .MAX_RETRY(MAX_RETRY), .POLL_LIMIT(POLL_LIMIT), .SETTLE_CYCLES(SETTLE_CYCLES)
) u_lane_ovr_chk (
  .clk(clk), .rst_n(rst_n), .phy_req(phy_req), .phy_we(phy_we),
  .phy_addr(phy_addr), .phy_wdata(phy_wdata), .phy_ack(phy_ack),
  .hreset_go(hreset_go), .done(done), .done_attempts(done_attempts),
  .settle_enter(settle_enter), .poll_ack(poll_ack)
);

// File: tb/lane_ovr_seq_bench.sv
module lane_ovr_seq_bench;
  localparam int MR = 3;
  localparam int PL = 4;
  localparam int SC = 5;
  localparam int ATT_W = $clog2(MR + 2);
  localparam logic [15:0] RXB = 16'h4A50;
  localparam logic [15:0] TXB = 16'hA7C4;
  localparam logic [15:0] GO_MARK = 16'hFFFF;

  // {lane[2], atten[4], online_at[3], det[2], halfrate[3], exp_online[1], exp_att[3]}
  localparam int NV = 6;
  localparam logic [17:0] VEC [NV] = '{
    {2'd0, 4'h5, 3'd1, 2'd3, 3'd0, 1'b1, 3'd1},
    {2'd1, 4'h2, 3'd3, 2'd3, 3'd2, 1'b1, 3'd3},
    {2'd2, 4'h9, 3'd2, 2'd1, 3'd1, 1'b1, 3'd2},
    {2'd3, 4'h7, 3'd0, 2'd3, 3'd0, 1'b0, 3'd4},
    {2'd1, 4'h0, 3'd0, 2'd0, 3'd3, 1'b0, 3'd1},
    {2'd0, 4'hF, 3'd0, 2'd2, 3'd1, 1'b0, 3'd4}
  };

  logic clk = 0, rst_n = 0;
  logic start_i = 0;
  logic [1:0] lane_i = 0;
  logic [3:0] atten_i = 0;
  logic phy_req, phy_we, hreset_go, done, done_online;
  logic [15:0] phy_addr, phy_wdata;
  logic phy_ack_i = 0, hreset_done_i = 0, hreset_online_i = 0;
  logic [15:0] phy_rdata_i = 0;
  logic [1:0] link_det_i = 0;
  logic [ATT_W-1:0] done_attempts;

  always #10 clk = ~clk;

  lane_ovr_seq #(.LANE_W(2), .MAX_RETRY(MR), .POLL_LIMIT(PL), .SETTLE_CYCLES(SC)) u_lane_ovr_seq (
    .clk(clk), .rst_n(rst_n), .start(start_i), .lane(lane_i), .tx_atten(atten_i),
    .phy_req(phy_req), .phy_we(phy_we), .phy_addr(phy_addr), .phy_wdata(phy_wdata),
    .phy_ack(phy_ack_i), .phy_rdata(phy_rdata_i), .hreset_go(hreset_go),
    .hreset_done(hreset_done_i), .hreset_online(hreset_online_i), .link_det(link_det_i),
    .done(done), .done_online(done_online), .done_attempts(done_attempts)
  );

  int checks = 0, errors = 0;
  int cyc = 0, wd = 0;

  // PHY and link model state
  int cfg_lane, cfg_online_at, cfg_det, cfg_h;
  int half_left, rst_wait, go_n, rd_n, bad_addr, done_n, log_n;
  bit pend_online;
  logic [15:0] log_addr [64];
  logic [15:0] log_data [64];
  int          log_cyc  [64];
  logic [15:0] exp_addr [64];
  logic [15:0] exp_data [64];
  int exp_n;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic log_put(input logic [15:0] a, input logic [15:0] d);
    if (log_n < 64) begin
      log_addr[log_n] = a;
      log_data[log_n] = d;
      log_cyc[log_n]  = cyc;
    end
    log_n++;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (done) done_n++;
    if (rst_n) begin
      if (phy_ack_i) phy_ack_i = 0;
      else if (phy_req) begin
        phy_ack_i = 1;
        if (phy_we) log_put(phy_addr, phy_wdata);
        else begin
          rd_n++;
          if (phy_addr == 16'(16'h2002 + cfg_lane * 256)) begin
            phy_rdata_i = RXB | 16'(half_left != 0);
            if (half_left != 0) half_left--;
          end else if (phy_addr == 16'(16'h2001 + cfg_lane * 256)) phy_rdata_i = TXB;
          else begin
            bad_addr++;
            phy_rdata_i = 16'h0;
          end
        end
      end
      if (phy_req && phy_we && !(phy_addr == 16'(16'h2005 + cfg_lane * 256) ||
                                 phy_addr == 16'(16'h2004 + cfg_lane * 256))) bad_addr++;
      if (hreset_go) begin
        go_n++;
        log_put(GO_MARK, 16'h0);
        half_left   = cfg_h;
        rst_wait    = 3;
        pend_online = (cfg_online_at != 0) && (go_n >= cfg_online_at);
        hreset_done_i = 0;
      end else if (rst_wait != 0) begin
        rst_wait--;
        if (rst_wait == 0) begin
          hreset_done_i   = 1;
          hreset_online_i = pend_online;
          link_det_i      = 2'(cfg_det);
        end
      end else hreset_done_i = 0;
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // Expected write log for one lane/attenuation over a number of attempts
  task automatic build_exp(input int ln, input logic [3:0] at, input int attempts,
                           input logic [15:0] rx_rd);
    logic [15:0] v;
    exp_n = 0;
    for (int k = 0; k < attempts; k++) begin
      exp_addr[exp_n] = 16'(16'h2005 + ln * 256); exp_data[exp_n] = RXB & ~16'h4000; exp_n++;
      exp_addr[exp_n] = GO_MARK; exp_data[exp_n] = 16'h0; exp_n++;
      v = rx_rd & ~16'h4000;
      exp_addr[exp_n] = 16'(16'h2005 + ln * 256); exp_data[exp_n] = v; exp_n++;
      v = v | 16'h4000;
      exp_addr[exp_n] = 16'(16'h2005 + ln * 256); exp_data[exp_n] = v; exp_n++;
      v = (v & ~16'h0700) | 16'h0300;
      exp_addr[exp_n] = 16'(16'h2005 + ln * 256); exp_data[exp_n] = v; exp_n++;
      v = v | 16'h0800;
      exp_addr[exp_n] = 16'(16'h2005 + ln * 256); exp_data[exp_n] = v; exp_n++;
      v = v & ~16'h0800;
      exp_addr[exp_n] = 16'(16'h2005 + ln * 256); exp_data[exp_n] = v; exp_n++;
      if (!at[3]) begin
        v = TXB & ~16'h8000;
        exp_addr[exp_n] = 16'(16'h2004 + ln * 256); exp_data[exp_n] = v; exp_n++;
        v = v | 16'h8000;
        exp_addr[exp_n] = 16'(16'h2004 + ln * 256); exp_data[exp_n] = v; exp_n++;
        v = v | (16'(at[2:0]) << 10);
        exp_addr[exp_n] = 16'(16'h2004 + ln * 256); exp_data[exp_n] = v; exp_n++;
      end
    end
  endtask

  task automatic setup(input int ln, input logic [3:0] at, input int on_at,
                       input int det, input int h);
    cfg_lane = ln; cfg_online_at = on_at; cfg_det = det; cfg_h = h;
    half_left = 0; go_n = 0; rd_n = 0; bad_addr = 0; log_n = 0; done_n = 0;
    @(negedge clk);
    lane_i = 2'(ln); atten_i = at; start_i = 1;
    @(negedge clk);
    start_i = 0;
  endtask

  task automatic wait_done(output bit seen, output bit onl, output int att);
    int n = 0;
    seen = 0; onl = 0; att = 0;
    while (n < 3000 && !seen) begin
      @(negedge clk);
      n++;
      if (done) begin
        seen = 1; onl = done_online; att = int'(done_attempts);
      end
    end
  endtask

  task automatic check_run(input logic [3:0] at, input int h, input int det,
                           input bit e_on, input int e_att);
    bit seen, onl;
    int att, first_bad;
    wait_done(seen, onl, att);
    chk(seen, "R11 done pulse seen", int'(seen), 1);
    @(negedge clk);
    chk(done == 0, "R11 done width one cycle", int'(done), 0);
    chk(done_n == 1, "R11 single done per run", done_n, 1);
    chk(onl == e_on, "R11 online flag", int'(onl), int'(e_on));
    chk(att == e_att, e_on ? "R11 attempt count" : "R9 attempt count", att, e_att);
    if (det == 0) chk(att == 1, "R10 early stop on no device", att, 1);
    chk(go_n == e_att, "R13 one strobe per attempt", go_n, e_att);
    chk(bad_addr == 0, "R2 stray address", bad_addr, 0);
    chk(rd_n == e_att * (h + 3 + (at[3] ? 0 : 1)), at[3] ? "R8 read count" : "R4 read count",
        rd_n, e_att * (h + 3 + (at[3] ? 0 : 1)));
    build_exp(cfg_lane, at, e_att, RXB);
    chk(log_n == exp_n, at[3] ? "R8 write count" : "R7 write count", log_n, exp_n);
    first_bad = -1;
    for (int i = 0; i < exp_n && i < 64; i++)
      if (first_bad < 0 && (log_addr[i] != exp_addr[i] || log_data[i] != exp_data[i])) first_bad = i;
    chk(first_bad < 0, "R3 R5 R7 write log order and values",
        first_bad < 0 ? 0 : int'({log_addr[first_bad], log_data[first_bad]}),
        first_bad < 0 ? 0 : int'({exp_addr[first_bad], exp_data[first_bad]}));
    if (!at[3] && log_n > 7)
      chk(log_cyc[7] - log_cyc[6] > SC, "R6 settle gap", log_cyc[7] - log_cyc[6], SC + 1);
  endtask

  initial begin
    bit seen, onl;
    int att;
    cfg_lane = 0; cfg_online_at = 0; cfg_det = 0; cfg_h = 0;
    half_left = 0; rst_wait = 0; go_n = 0; rd_n = 0; bad_addr = 0; done_n = 0; log_n = 0;
    pend_online = 0;
    repeat (3) @(negedge clk);
    chk(phy_req == 0, "R1 phy_req in reset", int'(phy_req), 0);
    chk(hreset_go == 0, "R1 hreset_go in reset", int'(hreset_go), 0);
    chk(done == 0, "R1 done in reset", int'(done), 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(phy_req == 0 && hreset_go == 0 && done == 0, "R1 idle after reset",
        int'({phy_req, hreset_go, done}), 0);

    for (int v = 0; v < NV; v++) begin
      setup(int'(VEC[v][17:16]), VEC[v][15:12], int'(VEC[v][11:9]),
            int'(VEC[v][8:7]), int'(VEC[v][6:4]));
      check_run(VEC[v][15:12], int'(VEC[v][6:4]), int'(VEC[v][8:7]),
                VEC[v][3], int'(VEC[v][2:0]));
      repeat (3) @(negedge clk);
    end

    // Half-rate that never clears within the poll limit
    setup(2, 4'h8, 1, 3, 7);
    wait_done(seen, onl, att);
    chk(seen && att == 1, "R4 saturated poll run ends", att, 1);
    chk(rd_n == 1 + PL + 1, "R4 poll stops at limit", rd_n, 1 + PL + 1);
    chk(log_n > 2 && log_data[2] == ((RXB | 16'h0001) & ~16'h4000), "R5 uses last read value",
        int'(log_data[2]), int'((RXB | 16'h0001) & ~16'h4000));
    repeat (3) @(negedge clk);

    // Start pulse during a run is ignored
    setup(1, 4'h3, 2, 3, 0);
    repeat (12) @(negedge clk);
    lane_i = 2'd3; atten_i = 4'h8; start_i = 1;
    @(negedge clk);
    start_i = 0;
    check_run(4'h3, 0, 3, 1'b1, 2);
    repeat (20) @(negedge clk);
    chk(done_n == 1 && phy_req == 0 && go_n == 2, "R12 extra start ignored",
        done_n * 100 + go_n, 102);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule